// File: doc/BRIEF.md
# Temperature-Aware Cluster Steering

This block chooses the back-end cluster that receives the next instruction in a clustered core. It reads four values for each cluster: an 8-bit temperature code, a flag that says whether the cluster can accept an instruction now, the number of inter-cluster copies the instruction would need if placed there, and the occupancy of that cluster's scheduler. It returns a cluster index and a stall flag. Both outputs are registered, so the decision for inputs presented in one cycle appears one cycle later.

A two-bit mode input selects the policy. The coldest policy considers temperature only. The gap-filtered policy ranks every cluster by temperature, drops the part of that ranking that lies above a temperature jump larger than a programmable threshold, and then takes the coldest survivor that can accept work. The balanced-thermal policy runs a two-round knockout between clusters. Temperature decides a match only when the two temperatures differ by more than the threshold. Otherwise communication count decides, then scheduler occupancy, then the lower index.

The block has no internal states and no enumerated state machine. It holds only the two output registers, which are loaded on every clock. The policy in use is selected by the mode input.

Top module: `therm_steer`

## Requirements
- R1: While reset is asserted and after its release before the first clock, `sel_cl` is 0 and `stall` is 0.
- R2: The outputs reflect the inputs sampled at a rising clock edge and are valid from that edge until the next one (one cycle of latency).
- R3: Mode encoding: 2'b00 selects coldest, 2'b01 selects gap-filtered, 2'b10 selects balanced-thermal, and 2'b11 behaves exactly as coldest.
- R4: In coldest mode the chosen cluster has the lowest temperature of all clusters whose `avail` bit is set. Among equal temperatures the lowest index wins.
- R5: A cluster whose `avail` bit (bit i for cluster i) is 0 is never chosen. In coldest and balanced-thermal modes `stall` is 1 exactly when no `avail` bit is set. Whenever `stall` is 1, `sel_cl` is 0.
- R6: In gap-filtered mode all clusters, available or not, are ranked by ascending temperature. At the first adjacent pair where the hotter one exceeds the colder by more than `thresh`, the hotter one and every cluster above it are discarded. The coldest available survivor is chosen, with ties going to the lower index.
- R7: In gap-filtered mode `stall` is 1 when no surviving cluster is available, even if a discarded cluster is.
- R8: In balanced-thermal mode, a match between two available candidates whose temperatures differ by more than `thresh` is won by the colder one.
- R9: In balanced-thermal mode, when the temperature difference is at most `thresh`, the candidate with fewer communications wins. If those are equal, the one with lower occupancy wins. An unavailable candidate always loses to an available one.
- R10: Balanced-thermal matches run as cluster 0 against 1 and cluster 2 against 3, and then the two winners meet. Any full tie goes to the lower index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Policy select (see R3) |
| thresh | input | 8 | Temperature gap threshold |
| temp_flat | input | 32 | Temperature code of cluster i in bits [8i+7:8i] |
| avail | input | 4 | Bit i set when cluster i can accept an instruction |
| comm_flat | input | 12 | Communication count of cluster i in bits [3i+2:3i] |
| occ_flat | input | 20 | Scheduler occupancy of cluster i in bits [5i+4:5i] |
| sel_cl | output | 2 | Chosen cluster index |
| stall | output | 1 | No eligible cluster |

## Verification
Every decision is due exactly one rising edge after its inputs are applied. The bench changes the inputs on a falling edge and compares both outputs on the next falling edge, which falls half a period after the register update. The reset values are read before the first edge after reset is released. The checker keeps a one-cycle copy of the inputs, so each property compares the outputs with the inputs from the edge that produced them.

// File: rtl/steer_pkg.sv
package steer_pkg;
    typedef enum logic [1:0] {
        MODE_COLD  = 2'b00,
        MODE_GAP   = 2'b01,
        MODE_THERM = 2'b10,
        MODE_COLD2 = 2'b11
    } steer_mode_e;
endpackage

// File: rtl/steer_cold_pick.sv
module steer_cold_pick #(
    parameter int NCL = 4,
    parameter int TW  = 8,
    localparam int IW = $clog2(NCL)
) (
    input  logic [NCL*TW-1:0] temps,
    input  logic [NCL-1:0]    mask,
    output logic              found,
    output logic [IW-1:0]     idx
);
    logic [TW-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NCL; i++) begin
            if (mask[i] && (!found || temps[i*TW +: TW] < best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = temps[i*TW +: TW];
            end
        end
    end
endmodule

// File: rtl/steer_gap_mask.sv
module steer_gap_mask #(
    parameter int NCL = 4,
    parameter int TW  = 8
) (
    input  logic [NCL*TW-1:0] temps,
    input  logic [TW-1:0]     thresh,
    output logic [NCL-1:0]    keep
);
    logic [TW-1:0] tmin;

    always_comb begin
        tmin = temps[TW-1:0];
        for (int i = 1; i < NCL; i++)
            if (temps[i*TW +: TW] < tmin) tmin = temps[i*TW +: TW];
    end

    // grow the kept set upward from the global minimum in steps of at most thresh
    always_comb begin
        for (int i = 0; i < NCL; i++) keep[i] = (temps[i*TW +: TW] == tmin);
        for (int it = 1; it < NCL; it++) begin
            for (int j = 0; j < NCL; j++) begin
                for (int k = 0; k < NCL; k++) begin
                    if (keep[k] && temps[j*TW +: TW] >= temps[k*TW +: TW] &&
                        (temps[j*TW +: TW] - temps[k*TW +: TW]) <= thresh)
                        keep[j] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/steer_tourney.sv
module steer_tourney #(
    parameter int NCL = 4,
    parameter int TW  = 8,
    parameter int CW  = 3,
    parameter int OW  = 5,
    localparam int IW = $clog2(NCL)
) (
    input  logic [NCL*TW-1:0] temps,
    input  logic [NCL*CW-1:0] comms,
    input  logic [NCL*OW-1:0] occs,
    input  logic [NCL-1:0]    avail,
    input  logic [TW-1:0]     thresh,
    output logic              found,
    output logic [IW-1:0]     idx
);
    logic          nv [2*NCL];
    logic [IW-1:0] ni [2*NCL];
    logic [TW-1:0] nt [2*NCL];
    logic [CW-1:0] nc [2*NCL];
    logic [OW-1:0] no [2*NCL];

    function automatic logic right_wins(
        input logic va, input logic [TW-1:0] ta, input logic [CW-1:0] ca, input logic [OW-1:0] oa,
        input logic vb, input logic [TW-1:0] tb, input logic [CW-1:0] cb, input logic [OW-1:0] ob,
        input logic [TW-1:0] th);
        logic [TW-1:0] gap;
        gap = (ta > tb) ? ta - tb : tb - ta;
        if (!va || !vb) return !va && vb;
        if (gap > th)   return tb < ta;
        if (ca != cb)   return cb < ca;
        return ob < oa;
    endfunction

    // heap layout: leaves at NCL+i, node n plays 2n (lower indices) against 2n+1
    always_comb begin
        nv[0] = 1'b0; ni[0] = '0; nt[0] = '0; nc[0] = '0; no[0] = '0;
        for (int i = 0; i < NCL; i++) begin
            nv[NCL+i] = avail[i];
            ni[NCL+i] = IW'(i);
            nt[NCL+i] = temps[i*TW +: TW];
            nc[NCL+i] = comms[i*CW +: CW];
            no[NCL+i] = occs[i*OW +: OW];
        end
        for (int n = NCL-1; n >= 1; n--) begin
            if (right_wins(nv[2*n], nt[2*n], nc[2*n], no[2*n],
                           nv[2*n+1], nt[2*n+1], nc[2*n+1], no[2*n+1], thresh)) begin
                nv[n] = nv[2*n+1]; ni[n] = ni[2*n+1]; nt[n] = nt[2*n+1];
                nc[n] = nc[2*n+1]; no[n] = no[2*n+1];
            end else begin
                nv[n] = nv[2*n]; ni[n] = ni[2*n]; nt[n] = nt[2*n];
                nc[n] = nc[2*n]; no[n] = no[2*n];
            end
        end
        found = nv[1];
        idx   = ni[1];
    end
endmodule

// File: rtl/therm_steer.sv
module therm_steer
    import steer_pkg::*;
#(
    parameter int NCL = 4,
    parameter int TW  = 8,
    parameter int CW  = 3,
    parameter int OW  = 5,
    localparam int IW = $clog2(NCL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [TW-1:0]     thresh,
    input  logic [NCL*TW-1:0] temp_flat,
    input  logic [NCL-1:0]    avail,
    input  logic [NCL*CW-1:0] comm_flat,
    input  logic [NCL*OW-1:0] occ_flat,
    output logic [IW-1:0]     sel_cl,
    output logic              stall
);
    logic          cold_f, gap_f, tour_f;
    logic [IW-1:0] cold_i, gap_i, tour_i;
    logic [NCL-1:0] keep;
    logic          pick_f;
    logic [IW-1:0] pick_i;

    steer_cold_pick #(.NCL(NCL), .TW(TW)) u_cold (
        .temps(temp_flat), .mask(avail), .found(cold_f), .idx(cold_i));

    steer_gap_mask #(.NCL(NCL), .TW(TW)) u_gap (
        .temps(temp_flat), .thresh(thresh), .keep(keep));

    steer_cold_pick #(.NCL(NCL), .TW(TW)) u_gap_pick (
        .temps(temp_flat), .mask(avail & keep), .found(gap_f), .idx(gap_i));

    steer_tourney #(.NCL(NCL), .TW(TW), .CW(CW), .OW(OW)) u_tour (
        .temps(temp_flat), .comms(comm_flat), .occs(occ_flat), .avail(avail),
        .thresh(thresh), .found(tour_f), .idx(tour_i));

    always_comb begin
        unique case (steer_mode_e'(mode))
            MODE_GAP:   begin pick_f = gap_f;  pick_i = gap_i;  end
            MODE_THERM: begin pick_f = tour_f; pick_i = tour_i; end
            default:    begin pick_f = cold_f; pick_i = cold_i; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_cl <= '0;
            stall  <= 1'b0;
        end else begin
            sel_cl <= pick_f ? pick_i : '0;
            stall  <= !pick_f;
        end
    end
endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
    parameter int NCL = 4,
    parameter int TW  = 8,
    localparam int IW = $clog2(NCL)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic [NCL*TW-1:0] temp_flat,
    input logic [NCL-1:0]    avail,
    input logic [IW-1:0]     sel_cl,
    input logic              stall
);
    logic              primed;
    logic [1:0]        mode_q;
    logic [NCL*TW-1:0] temp_q;
    logic [NCL-1:0]    avail_q;
    logic              coldest_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed <= 1'b0; mode_q <= '0; temp_q <= '0; avail_q <= '0;
        end else begin
            primed <= 1'b1; mode_q <= mode; temp_q <= temp_flat; avail_q <= avail;
        end
    end

    always_comb begin
        coldest_ok = 1'b1;
        for (int i = 0; i < NCL; i++)
            if (avail_q[i] && temp_q[i*TW +: TW] < temp_q[sel_cl*TW +: TW]) coldest_ok = 1'b0;
    end

    assert_reset_state_R1: assert property (@(posedge clk) !rst_n |=> (sel_cl == '0 && !stall || !rst_n));

    assert_sel_avail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !stall) |-> avail_q[sel_cl]);

    assert_stall_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (sel_cl == '0));

    assert_stall_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b01 && avail == '0) |=> stall);

    assert_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b01 && avail != '0) |=> !stall);

    assert_coldest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !stall && (mode_q == 2'b00 || mode_q == 2'b11)) |-> coldest_ok);
endmodule

bind therm_steer steer_chk #(.NCL(NCL), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .temp_flat(temp_flat),
    .avail(avail), .sel_cl(sel_cl), .stall(stall));

// File: tb/sim_therm_steer.sv
module sim_therm_steer;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = '0;
    logic [7:0]  thresh = '0;
    logic [31:0] temp_flat = '0;
    logic [3:0]  avail = '0;
    logic [11:0] comm_flat = '0;
    logic [19:0] occ_flat = '0;
    logic [1:0]  sel_cl;
    logic        stall;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    therm_steer u0 (.clk(clk), .rst_n(rst_n), .mode(mode), .thresh(thresh),
        .temp_flat(temp_flat), .avail(avail), .comm_flat(comm_flat),
        .occ_flat(occ_flat), .sel_cl(sel_cl), .stall(stall));

    function automatic int t_of(int i); return int'(temp_flat[i*8 +: 8]); endfunction
    function automatic int c_of(int i); return int'(comm_flat[i*3 +: 3]); endfunction
    function automatic int o_of(int i); return int'(occ_flat[i*5 +: 5]); endfunction

    // coldest among mask, lower index on equal temperature; -1 when empty
    function automatic int ref_coldest(logic [3:0] m);
        int b = -1;
        for (int i = 0; i < N; i++)
            if (m[i] && (b < 0 || t_of(i) < t_of(b))) b = i;
        return b;
    endfunction

    function automatic int ref_gap();
        int ord[4];
        logic [3:0] kept = '0;
        for (int i = 0; i < N; i++) ord[i] = i;
        for (int a = 0; a < N; a++)
            for (int b = 0; b < N-1; b++)
                if (t_of(ord[b]) > t_of(ord[b+1])) begin
                    int tmp = ord[b]; ord[b] = ord[b+1]; ord[b+1] = tmp;
                end
        kept[ord[0]] = 1'b1;
        for (int k = 1; k < N; k++) begin
            if (t_of(ord[k]) - t_of(ord[k-1]) > int'(thresh)) break;
            kept[ord[k]] = 1'b1;
        end
        return ref_coldest(kept & avail);
    endfunction

    function automatic int match(int a, int b);
        int d;
        if (a < 0) return b;
        if (b < 0) return a;
        d = t_of(a) - t_of(b); if (d < 0) d = -d;
        if (d > int'(thresh)) return (t_of(b) < t_of(a)) ? b : a;
        if (c_of(a) != c_of(b)) return (c_of(b) < c_of(a)) ? b : a;
        if (o_of(a) != o_of(b)) return (o_of(b) < o_of(a)) ? b : a;
        return a;
    endfunction

    function automatic int ref_therm();
        int p[4];
        for (int i = 0; i < N; i++) p[i] = avail[i] ? i : -1;
        return match(match(p[0], p[1]), match(p[2], p[3]));
    endfunction

    task automatic check(string req, int exp_sel, int exp_stall);
        checks++;
        if (int'(sel_cl) != exp_sel || int'(stall) != exp_stall) begin
            fails++;
            $display("FAIL %s: sel=%0d stall=%0d expected sel=%0d stall=%0d",
                     req, sel_cl, stall, exp_sel, exp_stall);
        end
    endtask

    // apply on falling edge, the result is registered at the next rising edge, compare on the following falling edge
    task automatic run(string req, logic [1:0] m, logic [7:0] th, logic [31:0] t,
                       logic [3:0] av, logic [11:0] cm, logic [19:0] oc);
        int e;
        mode = m; thresh = th; temp_flat = t; avail = av; comm_flat = cm; occ_flat = oc;
        case (m)
            2'b01:   e = ref_gap();
            2'b10:   e = ref_therm();
            default: e = ref_coldest(av);
        endcase
        @(negedge clk);
        if (e < 0) check(req, 0, 1); else check(req, e, 0);
    endtask

    function automatic logic [31:0] pk(int a, int b, int c, int d);
        return {8'(d), 8'(c), 8'(b), 8'(a)};
    endfunction

    initial begin
        #200000;
        fails++; checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7715));
        @(negedge clk);
        check("R1 reset", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 after release", 0, 0);

        run("R4 coldest", 2'b00, 8'd0, pk(40, 20, 30, 20), 4'b1111, '0, '0);
        run("R4 skip unavailable", 2'b00, 8'd0, pk(40, 20, 30, 10), 4'b0101, '0, '0);
        run("R3 mode 11 as coldest", 2'b11, 8'd0, pk(9, 8, 7, 6), 4'b1111, '0, '0);
        run("R5 stall coldest", 2'b00, 8'd3, pk(1, 2, 3, 4), 4'b0000, '0, '0);
        run("R5 stall thermal", 2'b10, 8'd3, pk(1, 2, 3, 4), 4'b0000, '0, '0);
        run("R2 next decision", 2'b00, 8'd0, pk(5, 5, 5, 1), 4'b1111, '0, '0);
        run("R7 gap discards available", 2'b01, 8'd5, pk(10, 12, 40, 41), 4'b1100, '0, '0);
        run("R6 gap wide threshold", 2'b01, 8'd30, pk(10, 12, 40, 41), 4'b1100, '0, '0);
        run("R6 gap chain", 2'b01, 8'd5, pk(10, 14, 18, 30), 4'b0110, '0, '0);
        run("R8 colder wins", 2'b10, 8'd5, pk(10, 30, 50, 70), 4'b1111, 12'hfff, '0);
        run("R9 comm then occupancy", 2'b10, 8'd255, pk(1, 2, 3, 4), 4'b1111,
            {3'd1, 3'd1, 3'd2, 3'd3}, {5'd2, 5'd5, 5'd0, 5'd0});
        run("R10 full tie lowest", 2'b10, 8'd255, pk(7, 7, 7, 7), 4'b1111, '0, '0);
        run("R10 pair structure", 2'b10, 8'd8, pk(0, 5, 12, 40), 4'b1111,
            {3'd0, 3'd1, 3'd2, 3'd3}, '0);
        run("R9 unavailable loses", 2'b10, 8'd0, pk(0, 90, 90, 90), 4'b1110, '0, '0);

        for (int n = 0; n < 600; n++) begin
            logic [31:0] t;
            logic [3:0]  av;
            for (int i = 0; i < N; i++) t[i*8 +: 8] = 8'($urandom_range(0, 60));
            for (int i = 0; i < N; i++) av[i] = ($urandom_range(0, 3) != 0);
            case (n % 3)
                0:       run("R4 random", 2'(($urandom_range(0, 1)) * 3), 8'($urandom_range(0, 20)),
                             t, av, 12'($urandom), 20'($urandom));
                1:       run("R6 random", 2'b01, 8'($urandom_range(0, 20)), t, av,
                             12'($urandom), 20'($urandom));
                default: run("R8 random", 2'b10, 8'($urandom_range(0, 20)), t, av,
                             12'($urandom), 20'($urandom));
            endcase
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule